// File: doc/BRIEF.md
# Receive code-group aligner and 5B/4B decoder

This block sits after the descrambler in a 100 Mb/s receive path. It gets one descrambled bit for each bit strobe. While no frame is open it looks for the start-of-stream delimiter pair (J then K) in a 10-bit window that slides one bit per strobe. A match fixes the 5-bit group boundary, and that boundary holds until the frame closes. The pair leaves the block as two preamble nibbles, and each later data group comes out as one 4-bit nibble with a one-cycle nibble strobe.

A frame closes on the end-of-stream pair (T then R), on two idle groups in a row, or as soon as the link-ok or signal-detect input drops. The delimiter groups make no nibbles. When decoding is switched off and the MII-mode flag is high, the raw five bits of each group leave the block instead, with the extra bit on the shared error/fifth-data pin.

Top module: `rx_group_decoder`

## Requirements
- R1: Group alignment is set by the first bit at which the last ten received bits equal 11000 10001 (J then K, earliest bit first). This works at any bit offset within the idle stream, and the boundary is not searched again while the frame is open.
- R2: Detection of J/K asserts rx_dv on the same clock as the first of two preamble nibbles. Both preamble nibbles are 4'h5, and the second one strobes on the next bit strobe.
- R3: Each later group is translated with the standard 4B/5B table (0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101). The nibble appears on rxd with nib_en high for one clock and rx_er_d4 low.
- R4: T (01101) followed by R (00111) closes the frame. rx_dv falls on the clock after the R group completes, and neither T nor R produces a nibble.
- R5: Two idle groups (11111) in a row close the frame. A single idle between data groups produces no nibble and leaves the frame open.
- R6: Inside a frame, a group that is neither data nor a delimiter (including J or K) produces a nibble with rx_er_d4=1 and rxd=0, and rx_dv stays high.
- R7: If link_ok or sig_det is low at a clock edge, rx_dv is low after that edge. No nibble is produced until a new J/K is found.
- R8: Bypass is active when decode_en=0 and mii_mode=1. In bypass each group is output raw: rxd is the last four bits received and rx_er_d4 is the first bit received. The two preamble strobes carry raw J (1,1000) and raw K (1,0001).
- R9: With decode_en=0 and mii_mode=0, the decoding of R3 still applies.
- R10: crs equals rx_dv at every nibble strobe and is low outside frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_in | input | 1 | Descrambled receive bit |
| bit_en | input | 1 | Strobe qualifying bit_in |
| link_ok | input | 1 | Link indication |
| sig_det | input | 1 | Signal detect |
| decode_en | input | 1 | 1 = decode, 0 = request raw output |
| mii_mode | input | 1 | MAC interface is MII |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er_d4 | output | 1 | Receive error, or fifth raw bit in bypass |
| crs | output | 1 | Carrier sense |
| nib_en | output | 1 | One-clock strobe per nibble |

## Verification
A wrong bit counter or a false alignment shows up at the ports straight away. Every nibble after the preamble then comes out mistranslated or flagged as an error, and the sweep over all five idle offsets with all sixteen data values exposes it on the first data group. A terminator flag that is stuck or cleared too early shows up one group later, either as a missing close after T/R or a double idle, or as a frame that closes early after one idle. Loss of link is expected to clear rx_dv within a single clock.

// File: rtl/rx_group_decoder.sv
module rx_group_decoder #(
  parameter int GW = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  input  logic       bit_en,
  input  logic       link_ok,
  input  logic       sig_det,
  input  logic       decode_en,
  input  logic       mii_mode,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er_d4,
  output logic       crs,
  output logic       nib_en
);
  localparam int WW = 2 * GW;
  localparam int CW = $clog2(GW);
  localparam logic [GW-1:0] SYM_J = 5'b11000;
  localparam logic [GW-1:0] SYM_K = 5'b10001;
  localparam logic [GW-1:0] SYM_T = 5'b01101;
  localparam logic [GW-1:0] SYM_I = 5'b11111;

  logic [WW-2:0] hist;
  logic [WW-1:0] win;
  logic [GW-1:0] grp;
  logic [CW-1:0] cnt;
  logic          frame, pend, t_seen, i_seen, byp;
  logic [3:0]    dnib;
  logic          dok;

  assign win = {hist, bit_in};
  assign grp = win[GW-1:0];
  assign byp = !decode_en && mii_mode;
  assign crs = rx_dv;

  always_comb begin
    dok = 1'b1;
    dnib = 4'h0;
    case (grp)
      5'b11110: dnib = 4'h0;
      5'b01001: dnib = 4'h1;
      5'b10100: dnib = 4'h2;
      5'b10101: dnib = 4'h3;
      5'b01010: dnib = 4'h4;
      5'b01011: dnib = 4'h5;
      5'b01110: dnib = 4'h6;
      5'b01111: dnib = 4'h7;
      5'b10010: dnib = 4'h8;
      5'b10011: dnib = 4'h9;
      5'b10110: dnib = 4'hA;
      5'b10111: dnib = 4'hB;
      5'b11010: dnib = 4'hC;
      5'b11011: dnib = 4'hD;
      5'b11100: dnib = 4'hE;
      5'b11101: dnib = 4'hF;
      default:  dok  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0; cnt <= '0;
      frame <= 1'b0; pend <= 1'b0; t_seen <= 1'b0; i_seen <= 1'b0;
      rxd <= 4'h0; rx_dv <= 1'b0; rx_er_d4 <= 1'b0; nib_en <= 1'b0;
    end else begin
      nib_en <= 1'b0;
      if (!link_ok || !sig_det) begin
        frame <= 1'b0; rx_dv <= 1'b0; pend <= 1'b0;
        if (bit_en) hist <= win[WW-2:0];
      end else if (bit_en) begin
        hist <= win[WW-2:0];
        if (!frame) begin
          if (win == {SYM_J, SYM_K}) begin
            frame <= 1'b1; rx_dv <= 1'b1; nib_en <= 1'b1; pend <= 1'b1;
            cnt <= '0; t_seen <= 1'b0; i_seen <= 1'b0;
            rxd <= byp ? SYM_J[3:0] : 4'h5;
            rx_er_d4 <= byp ? SYM_J[4] : 1'b0;
          end
        end else begin
          if (pend) begin
            pend <= 1'b0; nib_en <= 1'b1;
            rxd <= byp ? SYM_K[3:0] : 4'h5;
            rx_er_d4 <= byp ? SYM_K[4] : 1'b0;
          end
          cnt <= (cnt == CW'(GW - 1)) ? '0 : cnt + 1'b1;
          if (cnt == CW'(GW - 1)) begin
            if (t_seen) begin
              frame <= 1'b0; rx_dv <= 1'b0;
            end else if (grp == SYM_T) begin
              t_seen <= 1'b1;
            end else if (grp == SYM_I) begin
              if (i_seen) begin
                frame <= 1'b0; rx_dv <= 1'b0;
              end
              i_seen <= 1'b1;
            end else begin
              i_seen <= 1'b0; nib_en <= 1'b1;
              if (byp) begin
                rxd <= grp[3:0]; rx_er_d4 <= grp[4];
              end else begin
                rxd <= dok ? dnib : 4'h0; rx_er_d4 <= !dok;
              end
            end
          end
        end
      end
    end
  end
endmodule

module rx_group_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       link_ok,
  input logic       sig_det,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       crs,
  input logic       nib_en
);
  a_r2_dv_rises_with_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> nib_en);
  a_r7_loss_clears_dv: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_ok || !sig_det) |=> !rx_dv);
  a_r3_nibble_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    nib_en |-> $past(bit_en));
  a_r4_no_nibble_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_dv) |-> !nib_en);
  a_r10_crs_with_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    nib_en |-> (crs && rx_dv));
endmodule

bind rx_group_decoder rx_group_decoder_chk u_chk (.*);

// File: tb/rx_group_decoder_test.sv
module rx_group_decoder_test;
  localparam int PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_in = 1'b0, bit_en = 1'b0, link_ok = 1'b1, sig_det = 1'b1;
  logic decode_en = 1'b1, mii_mode = 1'b1;
  logic [3:0] rxd;
  logic rx_dv, rx_er_d4, crs, nib_en;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [6:0] got[$];
  logic [6:0] exp_q[$];

  always #(PERIOD/2) clk = ~clk;

  rx_group_decoder uut (.*);

  function automatic logic [4:0] enc(input logic [3:0] d);
    logic [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                          5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[d];
  endfunction

  always @(negedge clk) if (nib_en) got.push_back({crs, rx_dv, rx_er_d4, rxd});

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] ex);
    total++;
    if (act !== ex) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); bit_in = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic sgrp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) sbit(g[i]);
  endtask

  task automatic ex(input logic er, input logic [3:0] n);
    exp_q.push_back({1'b1, 1'b1, er, n});
  endtask

  task automatic start(input int off, input bit raw);
    for (int i = 0; i < 3; i++) sgrp(5'b11111);
    for (int i = 0; i < off; i++) sbit(1'b1);
    sgrp(5'b11000); sgrp(5'b10001);
    if (raw) begin ex(1'b1, 4'b1000); ex(1'b1, 4'b0001); end
    else begin ex(1'b0, 4'h5); ex(1'b0, 4'h5); end
  endtask

  task automatic tr_end;
    sgrp(5'b01101); sgrp(5'b00111);
  endtask

  task automatic compare(input string tag);
    sgrp(5'b11111); sgrp(5'b11111);
    repeat (3) @(negedge clk);
    chk({tag, " nibble count"}, got.size(), exp_q.size());
    if (got.size() == exp_q.size())
      foreach (got[i]) chk({tag, " nibble"}, got[i], exp_q[i]);
    chk({tag, " rx_dv low after"}, rx_dv, 1'b0);
    chk({tag, " R10 crs low after"}, crs, 1'b0);
    got.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset rx_dv", rx_dv, 0); chk("reset crs", crs, 0); chk("reset nib_en", nib_en, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4: every offset, all data values both orders
    for (int off = 0; off < 5; off++) begin
      start(off, 0);
      for (int d = 0; d < 16; d++) begin
        logic [3:0] v = (off % 2 == 0) ? 4'(d) : 4'(15 - d);
        sgrp(enc(v)); ex(1'b0, v);
      end
      tr_end();
      compare("R1 R2 R3 R4 sweep");
    end

    // R5: double idle closes, single idle dropped
    start(2, 0);
    sgrp(enc(4'h3)); ex(0, 4'h3);
    sgrp(5'b11111);
    sgrp(enc(4'hA)); ex(0, 4'hA);
    sgrp(5'b11111); sgrp(5'b11111);
    chk("R5 closed by two idles", rx_dv, 0);
    compare("R5 idles");

    // R6: invalid groups including J mid-frame
    start(1, 0);
    sgrp(enc(4'h7)); ex(0, 4'h7);
    sgrp(5'b00000); ex(1, 4'h0);
    chk("R6 rx_dv stays", rx_dv, 1);
    sgrp(5'b11000); ex(1, 4'h0);
    sgrp(5'b10001); ex(1, 4'h0);
    sgrp(enc(4'hC)); ex(0, 4'hC);
    tr_end();
    compare("R6 invalid");

    // R7: link loss and signal loss
    for (int k = 0; k < 2; k++) begin
      start(3, 0);
      sgrp(enc(4'h1)); ex(0, 4'h1);
      @(negedge clk);
      if (k == 0) link_ok = 1'b0; else sig_det = 1'b0;
      @(negedge clk);
      chk("R7 rx_dv cleared on loss", rx_dv, 0);
      link_ok = 1'b1; sig_det = 1'b1;
      for (int i = 0; i < 4; i++) sgrp(enc(4'h0));
      chk("R7 stays low", rx_dv, 0);
      tr_end();
      compare("R7 loss");
    end

    // R8: raw bypass
    decode_en = 1'b0; mii_mode = 1'b1;
    for (int off = 0; off < 5; off++) begin
      start(off, 1);
      for (int d = 0; d < 16; d++) begin
        logic [4:0] g = enc(4'(d));
        sgrp(g); ex(g[4], g[3:0]);
      end
      sgrp(5'b00000); ex(0, 4'h0);
      tr_end();
      compare("R8 bypass");
    end

    // R9: bypass request ignored without MII mode
    mii_mode = 1'b0;
    start(4, 0);
    for (int d = 0; d < 16; d++) begin sgrp(enc(4'(d))); ex(0, 4'(d)); end
    tr_end();
    compare("R9 no bypass");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule